// File: doc/BRIEF.md
# PLL Divider Coefficient Scrambling Encoder

This block converts a plain PLL divider value into the scrambled coefficient code that a PLL's divider registers expect. The code does not come from a table. A small shift register starts from a fixed seed and steps once for every index from the input value up to a fixed limit, inclusive. The state left in the register after the last step is the code. The smallest input values do not follow the loop: each of them maps to a fixed code.

Two lanes share the controller. The post-divider lane (mode 0) uses a 5-bit register and produces a 7-bit code. The pre-divider lane (mode 1) uses an 8-bit register and produces a 10-bit code. The N-lane seed, limit and fixed codes are parameters. A host pulses `start` with the mode and the value. It then waits for the one-cycle `done` pulse and takes `code`, which holds until a later result replaces it.

Top module: `pll_div_encoder`

## Requirements
- R1: In mode 0, a value v from 3 to 512 gives the following code. A 5-bit register is seeded with 0x10 and steps once for each index from v to 512 inclusive, which is 513-v steps. On each step, new bit 4 is bit 0 XOR bit 2, and bits 3..0 take the old bits 4..1. The final state appears in code[4:0], and code[9:5] is zero.
- R2: In mode 0, the values 0, 1 and 2 give the codes 0x7F, 0x62 and 0x42. The `done` pulse comes in the cycle after the start, and `busy` never rises.
- R3: In mode 1, a value v from 3 to 256 gives the following code. An 8-bit register is seeded with 0x80 and steps once for each index from v to 256 inclusive. On each step, new bit 7 is bit0^bit2^bit3^bit4, and bits 6..0 take the old bits 7..1. The final state appears in code[7:0], and code[9:8] is zero.
- R4: In mode 1, the values 0, 1 and 2 give the default codes 0x3FF, 0x302 and 0x202, with single-cycle latency.
- R5: For an iterative request that takes S steps, `busy` is high for the S+1 cycles after the start edge. `done` is high in the cycle after `busy` falls, and `busy` and `done` are never both high.
- R6: `done` lasts exactly one cycle. `code` changes only in a cycle where `done` is high.
- R7: A `start` while `busy` is high is ignored. The running request finishes with its own code at its own time.
- R8: After reset, `busy`, `done` and `code` are all zero.
- R9: A value above the lane's limit (3 or more) takes zero steps, and the code equals the seed: 0x10 in mode 0, 0x80 in mode 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request pulse, accepted only while idle |
| mode | input | 1 | 0: post-divider lane, 1: pre-divider lane |
| value | input | 10 | Plain divider value |
| busy | output | 1 | Shift register iterating |
| done | output | 1 | One-cycle result pulse |
| code | output | 10 | Scrambled coefficient, zero-filled above the lane width |

## Verification
The assertions assume that `mode` and `value` are stable in the cycle where `start` is accepted. They also assume that the value decoded in that cycle belongs to the request the host intends. The bench changes these inputs only half a clock away from the sampling edge, and it holds them alongside `start` for one full cycle. It sends extra starts only during a busy window, to probe the ignore rule. Every mode 0 value from 0 to 32 is run, along with N-lane specials, mid-range values, the limit itself and values above it.

// File: rtl/pde_pkg.sv
package pde_pkg;

  typedef enum logic {
    MODE_P = 1'b0,
    MODE_N = 1'b1
  } enc_mode_e;

  // Number of shift steps for one request: every index from val up to limit inclusive.
  function automatic logic [31:0] iter_count(input logic [31:0] val, input logic [31:0] limit);
    if (val > limit) return 32'd0;
    return limit - val + 32'd1;
  endfunction

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/pde_lfsr_step.sv
module pde_lfsr_step #(
  parameter int unsigned      W    = 5,
  parameter logic [W-1:0]     TAPS = 5'b00101
) (
  input  logic [W-1:0] cur,
  output logic [W-1:0] nxt
);
  // Feedback enters at the top bit, the rest shift toward bit 0.
  assign nxt = {^(cur & TAPS), cur[W-1:1]};
endmodule

// File: rtl/pde_special.sv
module pde_special #(
  parameter int unsigned VAL_W  = 10,
  parameter int unsigned CODE_W = 10,
  parameter int unsigned P_SP0  = 'h7F,
  parameter int unsigned P_SP1  = 'h62,
  parameter int unsigned P_SP2  = 'h42,
  parameter int unsigned N_SP0  = 'h3FF,
  parameter int unsigned N_SP1  = 'h302,
  parameter int unsigned N_SP2  = 'h202
) (
  input  logic              mode,
  input  logic [VAL_W-1:0]  value,
  output logic              hit,
  output logic [CODE_W-1:0] code
);
  import pde_pkg::*;

  assign hit = (value < VAL_W'(3));

  always_comb begin
    code = '0;
    if (enc_mode_e'(mode) == MODE_P) begin
      case (value[1:0])
        2'd0:    code = CODE_W'(P_SP0);
        2'd1:    code = CODE_W'(P_SP1);
        default: code = CODE_W'(P_SP2);
      endcase
    end else begin
      case (value[1:0])
        2'd0:    code = CODE_W'(N_SP0);
        2'd1:    code = CODE_W'(N_SP1);
        default: code = CODE_W'(N_SP2);
      endcase
    end
  end
endmodule

// File: rtl/pde_step_counter.sv
module pde_step_counter #(
  parameter int unsigned CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             dec,
  output logic [CNT_W-1:0] left,
  output logic             empty
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt_q <= '0;
    else if (load) cnt_q <= load_val;
    else if (dec)  cnt_q <= cnt_q - CNT_W'(1);
  end

  assign left  = cnt_q;
  assign empty = (cnt_q == '0);
endmodule

// File: rtl/pll_div_encoder.sv
module pll_div_encoder #(
  parameter int unsigned VAL_W    = 10,
  parameter int unsigned P_LFSR_W = 5,
  parameter int unsigned P_CODE_W = 7,
  parameter int unsigned P_TAPS   = 'b00101,
  parameter int unsigned P_SEED   = 'h10,
  parameter int unsigned P_LIMIT  = 'h200,
  parameter int unsigned P_SP0    = 'h7F,
  parameter int unsigned P_SP1    = 'h62,
  parameter int unsigned P_SP2    = 'h42,
  parameter int unsigned N_LFSR_W = 8,
  parameter int unsigned N_CODE_W = 10,
  parameter int unsigned N_TAPS   = 'h1D,
  parameter int unsigned N_SEED   = 'h80,
  parameter int unsigned N_LIMIT  = 'h100,
  parameter int unsigned N_SP0    = 'h3FF,
  parameter int unsigned N_SP1    = 'h302,
  parameter int unsigned N_SP2    = 'h202
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             mode,
  input  logic [VAL_W-1:0] value,
  output logic             busy,
  output logic             done,
  output logic [pde_pkg::max2(P_CODE_W, N_CODE_W)-1:0] code
);
  import pde_pkg::*;

  localparam int unsigned CODE_W    = max2(P_CODE_W, N_CODE_W);
  localparam int unsigned ST_W      = max2(P_LFSR_W, N_LFSR_W);
  localparam int unsigned LIMIT_MAX = max2(P_LIMIT, N_LIMIT);
  localparam int unsigned CNT_W     = $clog2(LIMIT_MAX + 2);

  // Registered state
  logic              busy_q, done_q, mode_q;
  logic [ST_W-1:0]   lfsr_q;
  logic [CODE_W-1:0] code_q;

  // Named internal events
  logic              accept;
  logic              finish;
  logic              spec_hit;
  logic [CODE_W-1:0] spec_code;
  logic [CNT_W-1:0]  steps_left;
  logic              cnt_empty;
  logic [CNT_W-1:0]  step_total;
  logic [ST_W-1:0]   seed_sel;
  logic [ST_W-1:0]   step_val;
  logic [CODE_W-1:0] result_code;

  assign accept = start & ~busy_q;
  assign finish = busy_q & cnt_empty;

  // One step instance per lane
  logic [P_LFSR_W-1:0] p_next;
  logic [N_LFSR_W-1:0] n_next;

  pde_lfsr_step #(.W(P_LFSR_W), .TAPS(P_LFSR_W'(P_TAPS))) u_step_p (
    .cur (lfsr_q[P_LFSR_W-1:0]),
    .nxt (p_next)
  );

  pde_lfsr_step #(.W(N_LFSR_W), .TAPS(N_LFSR_W'(N_TAPS))) u_step_n (
    .cur (lfsr_q[N_LFSR_W-1:0]),
    .nxt (n_next)
  );

  pde_special #(
    .VAL_W(VAL_W), .CODE_W(CODE_W),
    .P_SP0(P_SP0), .P_SP1(P_SP1), .P_SP2(P_SP2),
    .N_SP0(N_SP0), .N_SP1(N_SP1), .N_SP2(N_SP2)
  ) u_special (
    .mode  (mode),
    .value (value),
    .hit   (spec_hit),
    .code  (spec_code)
  );

  always_comb begin
    if (enc_mode_e'(mode) == MODE_P) begin
      step_total = CNT_W'(iter_count(32'(value), 32'(P_LIMIT)));
      seed_sel   = ST_W'(P_LFSR_W'(P_SEED));
    end else begin
      step_total = CNT_W'(iter_count(32'(value), 32'(N_LIMIT)));
      seed_sel   = ST_W'(N_LFSR_W'(N_SEED));
    end
  end

  always_comb begin
    if (enc_mode_e'(mode_q) == MODE_P) begin
      step_val    = ST_W'(p_next);
      result_code = CODE_W'(lfsr_q[P_LFSR_W-1:0]);
    end else begin
      step_val    = ST_W'(n_next);
      result_code = CODE_W'(lfsr_q[N_LFSR_W-1:0]);
    end
  end

  pde_step_counter #(.CNT_W(CNT_W)) u_counter (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (accept & ~spec_hit),
    .load_val (step_total),
    .dec      (busy_q & ~cnt_empty),
    .left     (steps_left),
    .empty    (cnt_empty)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      mode_q <= 1'b0;
      lfsr_q <= '0;
      code_q <= '0;
    end else begin
      done_q <= 1'b0;
      if (accept) begin
        mode_q <= mode;
        if (spec_hit) begin
          code_q <= spec_code;
          done_q <= 1'b1;
        end else begin
          busy_q <= 1'b1;
          lfsr_q <= seed_sel;
        end
      end else if (finish) begin
        busy_q <= 1'b0;
        done_q <= 1'b1;
        code_q <= result_code;
      end else if (busy_q) begin
        lfsr_q <= step_val;
      end
    end
  end

  assign busy = busy_q;
  assign done = done_q;
  assign code = code_q;

endmodule

// File: rtl/pde_encoder_checker.sv
module pde_encoder_checker #(
  parameter int unsigned VAL_W  = 10,
  parameter int unsigned CODE_W = 10,
  parameter int unsigned CNT_W  = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              mode,
  input logic [VAL_W-1:0]  value,
  input logic              busy,
  input logic              done,
  input logic [CODE_W-1:0] code,
  input logic              mode_q,
  input logic [CNT_W-1:0]  steps_left,
  input logic              cnt_empty
);

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R6

  AST_CODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(code)); // R6

  AST_BUSY_DONE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && done)); // R5

  AST_BUSY_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !cnt_empty) |=> busy); // R5

  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (start && busy && !cnt_empty) |=> (steps_left == $past(steps_left) - CNT_W'(1))); // R7

  AST_P_SPECIAL_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && !mode && value == VAL_W'(1)) |=> (done && code == CODE_W'('h62))); // R2

  AST_P_ZERO_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !mode_q) |-> (code >> 7) == '0); // R1

endmodule

bind pll_div_encoder pde_encoder_checker #(
  .VAL_W(VAL_W), .CODE_W(CODE_W), .CNT_W(CNT_W)
) u_chk (.*);

// File: tb/pll_div_encoder_tb.sv
module pll_div_encoder_tb;
  localparam int CLK_PERIOD = 10;
  localparam int P_LIM = 512;
  localparam int N_LIM = 256;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start_r = 1'b0;
  logic       mode_r = 1'b0;
  logic [9:0] val_r = '0;
  logic       busy, done;
  logic [9:0] code;

  int n_checks = 0;
  int n_fail   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pll_div_encoder u_dut (
    .clk(clk), .rst_n(rst_n), .start(start_r), .mode(mode_r),
    .value(val_r), .busy(busy), .done(done), .code(code)
  );

  // Reference results, written from the requirements
  function automatic int ref_p(input int v);
    int x;
    if (v == 0) return 'h7F;
    if (v == 1) return 'h62;
    if (v == 2) return 'h42;
    x = 'h10;
    for (int i = v; i <= P_LIM; i++) begin
      int fb;
      fb = (x & 1) ^ ((x / 4) & 1);
      x  = fb * 16 + (x / 2) % 16;
    end
    return x;
  endfunction

  function automatic int ref_n(input int v);
    int x;
    if (v == 0) return 'h3FF;
    if (v == 1) return 'h302;
    if (v == 2) return 'h202;
    x = 'h80;
    for (int i = v; i <= N_LIM; i++) begin
      int fb;
      fb = (x & 1) ^ ((x / 4) & 1) ^ ((x / 8) & 1) ^ ((x / 16) & 1);
      x  = fb * 128 + (x / 2) % 128;
    end
    return x;
  endfunction

  function automatic int ref_steps(input int m, input int v);
    int lim;
    lim = (m == 0) ? P_LIM : N_LIM;
    return (v > lim) ? 0 : lim - v + 1;
  endfunction

  function automatic int ref_code(input int m, input int v);
    return (m == 0) ? ref_p(v) : ref_n(v);
  endfunction

  // Cycle-by-cycle behavioural model
  int m_busy = 0, m_done = 0, m_code = 0, m_left = 0, m_result = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy = 0; m_done = 0; m_code = 0; m_left = 0;
    end else begin
      m_done = 0;
      if (start_r && m_busy == 0) begin
        if (val_r < 3) begin
          m_code = ref_code(int'(mode_r), int'(val_r));
          m_done = 1;
        end else begin
          m_busy   = 1;
          m_left   = ref_steps(int'(mode_r), int'(val_r));
          m_result = ref_code(int'(mode_r), int'(val_r));
        end
      end else if (m_busy != 0) begin
        if (m_left == 0) begin
          m_busy = 0; m_done = 1; m_code = m_result;
        end else begin
          m_left = m_left - 1;
        end
      end
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      check("R5 busy", int'(busy), m_busy);
      check("R6 done", int'(done), m_done);
      check("R1/R3 code", int'(code), m_code);
    end
  end

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  // Issue one request and wait for its done pulse; check the code there.
  task automatic run(input int m, input int v, input string tag);
    int waited;
    @(negedge clk); #1;
    start_r = 1'b1; mode_r = m[0]; val_r = v[9:0];
    @(negedge clk); #1;
    start_r = 1'b0;
    waited = 0;
    while (!done && waited < 1000) begin
      @(negedge clk); #2;
      waited++;
    end
    check(tag, int'(code), ref_code(m, v));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R8: reset values
    check("R8 busy", int'(busy), 0);
    check("R8 done", int'(done), 0);
    check("R8 code", int'(code), 0);
    @(negedge clk); #1;
    rst_n = 1'b1;

    // R2 and R1: every mode 0 value from 0 to 32
    for (int v = 0; v <= 32; v++) begin
      if (v < 3) run(0, v, "R2 special");
      else       run(0, v, "R1 iterate");
    end
    run(0, 511, "R1 near limit");
    run(0, 512, "R1 at limit");

    // R4 and R3: N lane
    run(1, 0, "R4 special0");
    run(1, 1, "R4 special1");
    run(1, 2, "R4 special2");
    run(1, 3, "R3 iterate");
    run(1, 100, "R3 iterate");
    run(1, 255, "R3 iterate");
    run(1, 256, "R3 at limit");

    // R9: above the limit the seed is returned
    run(0, 600, "R9 p seed");
    check("R9 p seed value", int'(code), 'h10);
    run(1, 300, "R9 n seed");
    check("R9 n seed value", int'(code), 'h80);

    // R7: start while busy is ignored
    @(negedge clk); #1;
    start_r = 1'b1; mode_r = 1'b0; val_r = 10'd400;
    @(negedge clk); #1;
    start_r = 1'b0;
    repeat (5) @(negedge clk);
    #1;
    start_r = 1'b1; mode_r = 1'b1; val_r = 10'd1;
    @(negedge clk); #1;
    start_r = 1'b0;
    check("R7 still busy", int'(busy), 1);
    while (!done) begin
      @(negedge clk); #2;
    end
    check("R7 own result", int'(code), ref_p(400));

    // R6: code held after done
    repeat (4) @(negedge clk);
    #2;
    check("R6 code held", int'(code), ref_p(400));
    check("R6 done low", int'(done), 0);

    finish_run();
  end
endmodule